// File: doc/BRIEF.md
# Outer-Level Return Validator

This block decides whether a far return that lowers privilege may go ahead. A return of this kind moves control to a caller with a numerically larger privilege level. The core starts the block with the current privilege level, the stack pointer, the byte count the return releases, and the limit of the current stack segment. The block then fetches four items through a request/response port: the popped code selector, the descriptor of that code selector, the popped stack selector, and the descriptor of that stack selector.

The block tests the items in a fixed order and stops at the first test that fails. It reports one of three fault classes: stack fault, general protection or not present. With the fault class it gives a 16-bit error code, which is either zero or one of the two popped selectors. If every test passes, the block reports no fault and gives the new privilege level. Updating the segment registers afterwards is the caller's job.

Top module: `ilr_ret_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `req_valid_o` are 0, `fault_o` is 00 and `err_code_o` is 0. No request is made while the block is idle.
- R2: The stack test runs first. If either `esp_i` or `esp_i`+7, computed without wraparound, is greater than `ss_limit_i`, the result is a stack fault (`fault_o`=01) with error code 0.
- R3: The return code selector is read by a stack read (`req_desc_o`=0) at `esp_i`+4, from the low 16 bits of `rsp_data_i`. If its RPL (bits 1:0) is not greater than the entry privilege level, the result is general protection (10) with the code selector as the error code.
- R4: A code selector whose bits 15:2 are all zero is treated as null. It gives general protection with that selector as the error code.
- R5: The code descriptor is fetched with `req_desc_o`=1 and the selector as the address. The response fields are: bit0 within table, bit1 present, bit2 non-system, bit3 executable, bit4 conforming or writable, and bits 6:5 DPL. A descriptor that is outside the table gives general protection with the code selector. A descriptor that is not an executable non-system one gives the same fault. The table test is made before the type test.
- R6: A code descriptor that passes R5 but is not present gives not-present (11) with the code selector as the error code. When a descriptor fails both the type test and the present test, the type failure is the one reported.
- R7: The privilege test on the code descriptor depends on its conforming bit. If the segment is nonconforming, its DPL must equal the code selector's RPL. If it is conforming, its DPL must not exceed that RPL. A violation gives general protection with the code selector.
- R8: The stack selector is read at `esp_i`+N+12, where N is `ret_imm_i`. If `esp_i`+N+15 is greater than `ss_limit_i`, the result is a stack fault with the stack selector as the error code. A value exactly equal to the limit passes.
- R9: A stack selector that is null gives general protection with the stack selector. So does a stack descriptor that is outside the table, and so does one that is not a writable non-system data descriptor.
- R10: A stack descriptor that is not present gives a stack fault (01), not a not-present fault, with the stack selector as the error code.
- R11: The stack descriptor's DPL must equal the code selector's RPL. The stack selector's RPL must equal that DPL. Either mismatch gives general protection with the stack selector.
- R12: When every test passes, `fault_o` is 00, `err_code_o` is 0 and `new_cpl_o` is the code selector's RPL. On a fault, `new_cpl_o` keeps the entry privilege level. `done_o` is high for exactly one cycle, and `busy_o` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a validation; accepted while the block is idle |
| cpl_i | input | 2 | Current privilege level |
| esp_i | input | 32 | Stack pointer at the return |
| ret_imm_i | input | 16 | Byte count the return releases (N) |
| ss_limit_i | input | 32 | Upper limit of the current stack segment |
| req_valid_o | output | 1 | Fetch request |
| req_desc_o | output | 1 | 1 = descriptor fetch by selector, 0 = stack read |
| req_addr_o | output | 32 | Stack byte address, or selector zero-extended |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_data_i | input | 32 | Stack word, or descriptor summary as in R5 |
| busy_o | output | 1 | Validation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | 00 none, 01 stack, 10 general protection, 11 not present |
| err_code_o | output | 16 | Error code of the reported fault |
| new_cpl_o | output | 2 | Privilege level after the return |

## Verification
The bench breaks each test in the chain in turn and keeps every earlier test passing. That way each expected fault class and error code shows that the right test fired and that the order is correct. Descriptors that fail two tests at once show which failure takes priority. Stack sizes right at the limit, one byte past it, and past the top of the 32-bit address space separate an inclusive bound from an exclusive one and show that a wrapped sum is caught. The conforming and nonconforming descriptors cover DPL both above and below the selector's RPL, which distinguishes the two privilege rules. The memory model answers only the expected addresses, so a wrong stack offset shows up as a wrong selector.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SF   = 2'b01,
    FLT_GP   = 2'b10,
    FLT_NP   = 2'b11
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SP, S_RD_CS, S_CS, S_RD_CSD, S_CSD, S_RD_SS, S_SS, S_RD_SSD, S_SSD
  } state_e;

  // descriptor summary bit positions
  localparam int unsigned D_INTBL = 0;
  localparam int unsigned D_PRES  = 1;
  localparam int unsigned D_NSYS  = 2;
  localparam int unsigned D_EXEC  = 3;
  localparam int unsigned D_CW    = 4;
  localparam int unsigned D_DPL   = 5;
  localparam int unsigned D_W     = 7;
endpackage

// File: rtl/ilr_bound_chk.sv
module ilr_bound_chk #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] limit_i,
  output logic          ok_o
);
  logic [AW:0] sum;
  assign sum  = {1'b0, base_i} + {1'b0, off_i};
  assign ok_o = sum <= {1'b0, limit_i};
endmodule

// File: rtl/ilr_desc_rules.sv
module ilr_desc_rules
  import ilr_pkg::*;
#(
  parameter int unsigned DW = D_W
) (
  input  logic [DW-1:0] desc_i,
  input  logic          is_code_i,
  input  logic [1:0]    sel_rpl_i,
  input  logic [1:0]    cs_rpl_i,
  output fault_e        fault_o
);
  logic [1:0] dpl;
  logic       type_ok, priv_ok;
  assign dpl = desc_i[D_DPL+:2];

  always_comb begin
    if (is_code_i) begin
      type_ok = desc_i[D_NSYS] & desc_i[D_EXEC];
      priv_ok = desc_i[D_CW] ? (dpl <= sel_rpl_i) : (dpl == sel_rpl_i);
    end else begin
      type_ok = desc_i[D_NSYS] & ~desc_i[D_EXEC] & desc_i[D_CW];
      priv_ok = (dpl == cs_rpl_i) && (sel_rpl_i == dpl);
    end
    if (!desc_i[D_INTBL] || !type_ok) fault_o = FLT_GP;
    else if (!desc_i[D_PRES])         fault_o = is_code_i ? FLT_NP : FLT_SF;
    else if (!priv_ok)                fault_o = FLT_GP;
    else                              fault_o = FLT_NONE;
  end
endmodule

// File: rtl/ilr_ret_seq.sv
module ilr_ret_seq
  import ilr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 16,
  parameter int unsigned NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    cpl_i,
  input  logic [AW-1:0] esp_i,
  input  logic [NW-1:0] ret_imm_i,
  input  logic [AW-1:0] ss_limit_i,
  output logic          req_valid_o,
  output logic          req_desc_o,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [AW-1:0] rsp_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    fault_o,
  output logic [SW-1:0] err_code_o,
  output logic [1:0]    new_cpl_o
);
  localparam int unsigned NCHK   = 3;
  localparam int unsigned CS_OFF = 4;
  localparam int unsigned SS_OFF = 12;
  localparam int unsigned TOP_OFF = 15;
  localparam int unsigned LO_OFF = 7;

  state_e        state_q, state_d;
  logic [1:0]    cpl_q;
  logic [AW-1:0] esp_q, lim_q, imm_ext;
  logic [NW-1:0] imm_q;
  logic [SW-1:0] cs_q, ss_q;
  logic [D_W-1:0] desc_q;
  logic          done_q;
  fault_e        fault_q;
  logic [SW-1:0] err_q;
  logic [1:0]    ncpl_q;

  logic          fin;
  fault_e        fin_fault;
  logic [SW-1:0] fin_err;
  fault_e        rule_fault;
  logic          cs_null, ss_null;

  assign imm_ext = {{(AW-NW){1'b0}}, imm_q};
  assign cs_null = cs_q[SW-1:2] == '0;
  assign ss_null = ss_q[SW-1:2] == '0;

  // bound checks: esp, esp+7, esp+N+15
  logic [AW-1:0] chk_off [NCHK];
  logic [NCHK-1:0] chk_ok;
  assign chk_off[0] = '0;
  assign chk_off[1] = AW'(LO_OFF);
  assign chk_off[2] = imm_ext + AW'(TOP_OFF);

  for (genvar g = 0; g < NCHK; g++) begin : g_bnd
    ilr_bound_chk #(.AW(AW)) u_bnd (
      .base_i (esp_q),
      .off_i  (chk_off[g]),
      .limit_i(lim_q),
      .ok_o   (chk_ok[g])
    );
  end

  ilr_desc_rules #(.DW(D_W)) u_rules (
    .desc_i   (desc_q),
    .is_code_i(state_q == S_CSD),
    .sel_rpl_i(state_q == S_CSD ? cs_q[1:0] : ss_q[1:0]),
    .cs_rpl_i (cs_q[1:0]),
    .fault_o  (rule_fault)
  );

  always_comb begin
    state_d     = state_q;
    fin         = 1'b0;
    fin_fault   = FLT_NONE;
    fin_err     = '0;
    req_valid_o = 1'b0;
    req_desc_o  = 1'b0;
    req_addr_o  = '0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_SP;
      S_SP: begin
        if (!(chk_ok[0] && chk_ok[1])) begin
          fin = 1'b1; fin_fault = FLT_SF;
        end else state_d = S_RD_CS;
      end
      S_RD_CS: begin
        req_valid_o = 1'b1;
        req_addr_o  = esp_q + AW'(CS_OFF);
        if (rsp_valid_i) state_d = S_CS;
      end
      S_CS: begin
        if (cs_q[1:0] <= cpl_q || cs_null) begin
          fin = 1'b1; fin_fault = FLT_GP; fin_err = cs_q;
        end else state_d = S_RD_CSD;
      end
      S_RD_CSD: begin
        req_valid_o = 1'b1;
        req_desc_o  = 1'b1;
        req_addr_o  = {{(AW-SW){1'b0}}, cs_q};
        if (rsp_valid_i) state_d = S_CSD;
      end
      S_CSD: begin
        if (rule_fault != FLT_NONE) begin
          fin = 1'b1; fin_fault = rule_fault; fin_err = cs_q;
        end else state_d = S_RD_SS;
      end
      S_RD_SS: begin
        req_valid_o = 1'b1;
        req_addr_o  = esp_q + imm_ext + AW'(SS_OFF);
        if (rsp_valid_i) state_d = S_SS;
      end
      S_SS: begin
        if (!chk_ok[2]) begin
          fin = 1'b1; fin_fault = FLT_SF; fin_err = ss_q;
        end else if (ss_null) begin
          fin = 1'b1; fin_fault = FLT_GP; fin_err = ss_q;
        end else state_d = S_RD_SSD;
      end
      S_RD_SSD: begin
        req_valid_o = 1'b1;
        req_desc_o  = 1'b1;
        req_addr_o  = {{(AW-SW){1'b0}}, ss_q};
        if (rsp_valid_i) state_d = S_SSD;
      end
      S_SSD: begin
        fin       = 1'b1;
        fin_fault = rule_fault;
        fin_err   = (rule_fault == FLT_NONE) ? '0 : ss_q;
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cpl_q   <= '0;
      esp_q   <= '0;
      imm_q   <= '0;
      lim_q   <= '0;
      cs_q    <= '0;
      ss_q    <= '0;
      desc_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      err_q   <= '0;
      ncpl_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (state_q == S_IDLE && start_i) begin
        cpl_q <= cpl_i;
        esp_q <= esp_i;
        imm_q <= ret_imm_i;
        lim_q <= ss_limit_i;
      end
      if (rsp_valid_i) begin
        if (state_q == S_RD_CS) cs_q <= rsp_data_i[SW-1:0];
        if (state_q == S_RD_SS) ss_q <= rsp_data_i[SW-1:0];
        if (state_q == S_RD_CSD || state_q == S_RD_SSD) desc_q <= rsp_data_i[D_W-1:0];
      end
      if (fin) begin
        fault_q <= fin_fault;
        err_q   <= fin_err;
        ncpl_q  <= (fin_fault == FLT_NONE) ? cs_q[1:0] : cpl_q;
      end
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign err_code_o = err_q;
  assign new_cpl_o  = ncpl_q;
endmodule

// File: rtl/ilr_ret_chk.sv
module ilr_ret_chk #(
  parameter int unsigned SW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          req_valid_o,
  input logic [1:0]    fault_o,
  input logic [SW-1:0] err_code_o,
  input logic [1:0]    new_cpl_o,
  input logic [1:0]    cpl_q,
  input logic [SW-1:0] cs_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o); // R1

  AST_OK_OUTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 2'b00) |-> new_cpl_o > cpl_q); // R3

  AST_NP_CODE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 2'b11) |-> err_code_o == cs_q); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R12
endmodule

bind ilr_ret_seq ilr_ret_chk #(.SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .req_valid_o(req_valid_o),
  .fault_o    (fault_o),
  .err_code_o (err_code_o),
  .new_cpl_o  (new_cpl_o),
  .cpl_q      (cpl_q),
  .cs_q       (cs_q)
);

// File: tb/test_ilr_ret_seq.sv
module test_ilr_ret_seq;
  localparam int unsigned NV = 23;

  function automatic logic [6:0] dsc(bit in_t, bit p, bit s, bit x, bit cw, logic [1:0] dpl);
    return {dpl, cw, x, s, p, in_t};
  endfunction

  typedef struct packed {
    logic [1:0]  cpl;
    logic [31:0] esp;
    logic [15:0] n;
    logic [31:0] lim;
    logic [15:0] cs;
    logic [6:0]  csd;
    logic [15:0] ss;
    logic [6:0]  ssd;
    logic [1:0]  flt;
    logic [15:0] err;
    logic [1:0]  ncpl;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [6:0] CG = 7'b11_0_1_1_1_1;  // code, dpl3, nonconforming
  localparam logic [6:0] SG = 7'b11_1_0_1_1_1;  // writable data, dpl3

  localparam vec_t VEC [NV] = '{
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, SG, 2'd0, 16'h0, 2'd3, 8'd12},          // R12 pass
    '{2'd0, 32'hFFF9, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, SG, 2'd1, 16'h0, 2'd0, 8'd2},          // R2 esp+7 over
    '{2'd0, 32'hFFFF_FFFC, 16'd0, 32'hFFFF_FFFF, 16'h1B, CG, 16'h23, SG, 2'd1, 16'h0, 2'd0, 8'd2}, // R2 wrap
    '{2'd3, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, SG, 2'd2, 16'h1B, 2'd3, 8'd3},          // R3 rpl==cpl
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h03, CG, 16'h23, SG, 2'd2, 16'h03, 2'd0, 8'd4},          // R4 null cs
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b11_0_1_1_1_0, 16'h23, SG, 2'd2, 16'h1B, 2'd0, 8'd5}, // R5 table
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b11_0_0_1_1_1, 16'h23, SG, 2'd2, 16'h1B, 2'd0, 8'd5}, // R5 not code
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b11_0_1_1_0_1, 16'h23, SG, 2'd3, 16'h1B, 2'd0, 8'd6}, // R6 absent
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b11_0_0_1_0_1, 16'h23, SG, 2'd2, 16'h1B, 2'd0, 8'd6}, // R6 type first
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b10_0_1_1_1_1, 16'h23, SG, 2'd2, 16'h1B, 2'd0, 8'd7}, // R7 noncf dpl<rpl
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, 7'b10_1_1_1_1_1, 16'h23, SG, 2'd0, 16'h0, 2'd3, 8'd7},  // R7 conf dpl<rpl ok
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1A, 7'b11_1_1_1_1_1, 16'h23, SG, 2'd2, 16'h1A, 2'd0, 8'd7}, // R7 conf dpl>rpl
    '{2'd0, 32'h100, 16'hFFF0, 32'hFFFF, 16'h1B, CG, 16'h23, SG, 2'd1, 16'h23, 2'd0, 8'd8},       // R8 over
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h03, SG, 2'd2, 16'h03, 2'd0, 8'd9},          // R9 null ss
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, 7'b11_1_0_1_1_0, 2'd2, 16'h23, 2'd0, 8'd9}, // R9 table
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, 7'b11_1_1_1_1_1, 2'd2, 16'h23, 2'd0, 8'd9}, // R9 code seg
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, 7'b11_0_0_1_1_1, 2'd2, 16'h23, 2'd0, 8'd9}, // R9 read-only
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, 7'b11_1_0_1_0_1, 2'd1, 16'h23, 2'd0, 8'd10}, // R10 absent
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1B, CG, 16'h23, 7'b10_1_0_1_1_1, 2'd2, 16'h23, 2'd0, 8'd11}, // R11 dpl!=cs rpl
    '{2'd0, 32'h100, 16'd0, 32'hFFFF, 16'h1A, 7'b10_0_1_1_1_1, 16'h23, 7'b10_1_0_1_1_1, 2'd2, 16'h23, 2'd0, 8'd11}, // R11 ss rpl
    '{2'd1, 32'h100, 16'd8, 32'hFFFF, 16'h1A, 7'b10_0_1_1_1_1, 16'h22, 7'b10_1_0_1_1_1, 2'd0, 16'h0, 2'd2, 8'd12}, // R12 cpl2
    '{2'd0, 32'h100, 16'd8, 32'h117, 16'h1B, CG, 16'h23, SG, 2'd0, 16'h0, 2'd3, 8'd8},            // R8 at limit
    '{2'd0, 32'h100, 16'd8, 32'h116, 16'h1B, CG, 16'h23, SG, 2'd1, 16'h23, 2'd0, 8'd8}            // R8 one past
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cpl_i;
  logic [31:0] esp_i, ss_limit_i, req_addr_o, rsp_data_i;
  logic [15:0] ret_imm_i, err_code_o;
  logic        req_valid_o, req_desc_o, rsp_valid_i, busy_o, done_o;
  logic [1:0]  fault_o, new_cpl_o;
  vec_t        cur;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  ilr_ret_seq i_ilr_ret_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cpl_i(cpl_i), .esp_i(esp_i),
    .ret_imm_i(ret_imm_i), .ss_limit_i(ss_limit_i), .req_valid_o(req_valid_o),
    .req_desc_o(req_desc_o), .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i),
    .rsp_data_i(rsp_data_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .err_code_o(err_code_o), .new_cpl_o(new_cpl_o)
  );

  // memory model: answers only the expected addresses
  always_comb begin
    rsp_valid_i = req_valid_o;
    rsp_data_i  = 32'hDEAD_BEEF;
    if (!req_desc_o) begin
      if (req_addr_o == cur.esp + 32'd4) rsp_data_i = {16'h0, cur.cs};
      else if (req_addr_o == cur.esp + {16'h0, cur.n} + 32'd12) rsp_data_i = {16'h0, cur.ss};
    end else begin
      rsp_data_i = '0;
      if (req_addr_o == {16'h0, cur.cs}) rsp_data_i = {25'h0, cur.csd};
      else if (req_addr_o == {16'h0, cur.ss}) rsp_data_i = {25'h0, cur.ssd};
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 50000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, input int idx);
    int t = 0;
    string tag;
    tag = $sformatf("R%0d vec%0d", v.rq, idx);
    cur = v;
    cpl_i = v.cpl; esp_i = v.esp; ret_imm_i = v.n; ss_limit_i = v.lim;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && t < 100) begin @(negedge clk_i); t++; end
    check(done_o === 1'b1, {tag, " done"}, 32'(done_o), 1);
    check(fault_o === v.flt, {tag, " fault"}, 32'(fault_o), 32'(v.flt));
    check(err_code_o === v.err, {tag, " err"}, 32'(err_code_o), 32'(v.err));
    check(new_cpl_o === v.ncpl, {tag, " cpl"}, 32'(new_cpl_o), 32'(v.ncpl));
    check(busy_o === 1'b0, {tag, " busy at done"}, 32'(busy_o), 0);
    @(negedge clk_i);
    check(done_o === 1'b0, "R12 done single pulse", 32'(done_o), 0);
  endtask

  initial begin
    cur = VEC[0];
    cpl_i = '0; esp_i = '0; ret_imm_i = '0; ss_limit_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o === 1'b0 && done_o === 1'b0 && req_valid_o === 1'b0, "R1 reset ctrl",
          {29'h0, busy_o, done_o, req_valid_o}, 0);
    check(fault_o === 2'b00 && err_code_o === 16'h0, "R1 reset result",
          {14'h0, fault_o, err_code_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o === 1'b0 && req_valid_o === 1'b0, "R1 idle after reset",
          {30'h0, busy_o, req_valid_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R2 fault path issues no request
    cur = VEC[1];
    cpl_i = cur.cpl; esp_i = cur.esp; ret_imm_i = cur.n; ss_limit_i = cur.lim;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(req_valid_o === 1'b0, "R2 no fetch before stack test", 32'(req_valid_o), 0);
    @(negedge clk_i);
    check(done_o === 1'b1 && req_valid_o === 1'b0 && fault_o === 2'b01, "R2 early stop",
          {30'h0, done_o, req_valid_o}, 2);

    // R1 reset mid-run clears outputs
    cur = VEC[0];
    cpl_i = cur.cpl; esp_i = cur.esp; ret_imm_i = cur.n; ss_limit_i = cur.lim;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(busy_o === 1'b0 && req_valid_o === 1'b0 && fault_o === 2'b00, "R1 reset mid-run",
          {29'h0, busy_o, req_valid_o, |fault_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule